// File: doc/BRIEF.md
# Pixel Hit Latency Delay with Trigger Coincidence

This block sits inside one pixel of a readout matrix. It holds a discriminator hit for the length of the trigger latency and decides whether that hit belongs to a triggered event. It uses no shift register as deep as the latency. When a hit arrives, a free storage slot records the value on a shared timestamp bus. The bus carries a Gray-coded count that runs up and then back down. It shows the values 0 through n, holds each end value for two cycles, and repeats every P = 2n+2 cycles, so every value appears twice per period. Each clock the slot compares its stored stamp with the live bus and counts the equalities. The capture cycle itself counts as the first equality. On the third equality, which falls exactly P cycles after the hit, the slot raises an expiry and frees itself.

An expiry that meets the one-clock trigger in the same cycle produces a coincidence strobe. That strobe is the write enable for the pixel's event buffer. The pixel has several slots, two by default, so that many hits can wait at the same time. A hit that finds every slot busy is lost and sets a sticky overflow flag. A mask input silences the pixel.

Top module: `hitdly_pixel`

## Requirements
- R1: While reset is asserted and right after it, `coinc_o` and `overflow_o` are 0 and every slot is free.
- R2: An unmasked hit in cycle c, with the bus repeating the up/down sequence of period P, expires in cycle c+P. The capture counts as the first equality and the expiry is the third. If `trig_i` is high in cycle c+P, `coinc_o` is high in cycle c+P+1 and in no other cycle for that hit.
- R3: `coinc_o` is high only in the cycle after a cycle in which an expiry and `trig_i` are both high. A trigger with no expiry gives no strobe, and an expiry with no trigger gives no strobe.
- R4: An expiring slot becomes free. A hit whose expiry misses the trigger never produces a strobe later.
- R5: With two slots, two hits a few cycles apart are both held, and each gives its own strobe at its own c+P+1.
- R6: A hit that arrives while all slots are busy is dropped. It never gives a strobe, and it sets `overflow_o`, which stays 1 until reset.
- R7: A hit with `mask_i` = 0 is ignored. It takes no slot, gives no strobe and does not set `overflow_o`.
- R8: A hit in the same cycle as a slot's expiry, when all slots are otherwise busy, is captured by the slot being freed. It is not dropped and gives its strobe P cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_i | input | 1 | Discriminator hit, one cycle per hit |
| mask_i | input | 1 | 1 enables the pixel, 0 ignores its hits |
| ts_gray_i | input | TS_W (8) | Gray-coded timestamp bus |
| trig_i | input | 1 | Trigger, one clock wide |
| coinc_o | output | 1 | Coincidence strobe (event buffer write) |
| overflow_o | output | 1 | Sticky flag: a hit was lost because all slots were busy |

## Verification
Every hit's result is due exactly P+1 cycles after the hit: P cycles until the third bus equality, plus one register on the strobe. The bench generates the up/down bus from its own cycle counter. Its driver pushes each expected strobe cycle, found by adding P+1 to the hit cycle, into a queue. The monitor samples `coinc_o` on every falling edge and treats a strobe in any cycle other than the head of the queue as a failure. Overflow is sampled at fixed cycles after the scenario that should, or should not, have set it.

// File: rtl/hitdly_pkg.sv
package hitdly_pkg;

   // equality count held in a slot: capture counts as the first equality
   typedef logic [1:0] mcnt_t;

   localparam mcnt_t MCNT_IDLE  = 2'd0;
   localparam mcnt_t MCNT_FIRST = 2'd1;
   // count value on which the next equality is the expiring (third) one
   localparam mcnt_t MCNT_LAST  = 2'd2;

endpackage

// File: rtl/hitdly_unit.sv
module hitdly_unit
   import hitdly_pkg::*;
#(
   parameter int TS_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [TS_W-1:0] ts_i,
   input  logic            load_i,
   output logic            busy_o,
   output logic            expire_o
);

   logic            busy_q;
   logic [TS_W-1:0] stamp_q;
   mcnt_t           cnt_q;
   logic            match;

   assign match    = busy_q && (stamp_q == ts_i);
   assign expire_o = match && (cnt_q == MCNT_LAST);
   assign busy_o   = busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         stamp_q <= '0;
         cnt_q   <= MCNT_IDLE;
      end else if (load_i) begin
         // a load wins over a simultaneous expiry: the slot is reused at once
         busy_q  <= 1'b1;
         stamp_q <= ts_i;
         cnt_q   <= MCNT_FIRST;
      end else if (expire_o) begin
         busy_q  <= 1'b0;
         cnt_q   <= MCNT_IDLE;
      end else if (match) begin
         cnt_q   <= cnt_q + 2'd1;
      end
   end

   // R2
   load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (busy_o && stamp_q == $past(ts_i)));

   // R4
   expire_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_o && !load_i) |=> !busy_o);

   // R2
   stamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !load_i && !expire_o) |=> ($stable(stamp_q) && busy_o));

endmodule

// File: rtl/hitdly_alloc.sv
module hitdly_alloc #(
   parameter int NUM_UNITS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_i,
   input  logic [NUM_UNITS-1:0] free_i,
   output logic [NUM_UNITS-1:0] grant_o,
   output logic                 drop_o
);

   generate
      if (NUM_UNITS == 1) begin : g_single
         assign grant_o = req_i & free_i;
      end else begin : g_prio
         // lowest index free slot takes the hit
         always_comb begin
            logic found;
            found   = 1'b0;
            grant_o = '0;
            for (int i = 0; i < NUM_UNITS; i++) begin
               if (req_i && free_i[i] && !found) begin
                  grant_o[i] = 1'b1;
                  found      = 1'b1;
               end
            end
         end
      end
   endgenerate

   assign drop_o = req_i && (free_i == '0);

   // R6
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));

   // R8
   grant_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && free_i != '0) |-> ($countones(grant_o) == 1));

endmodule

// File: rtl/hitdly_pixel.sv
module hitdly_pixel
   import hitdly_pkg::*;
#(
   parameter int TS_W       = 8,
   parameter int NUM_UNITS  = 2,
   parameter bit STROBE_REG = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hit_i,
   input  logic            mask_i,
   input  logic [TS_W-1:0] ts_gray_i,
   input  logic            trig_i,
   output logic            coinc_o,
   output logic            overflow_o
);

   localparam int UW = NUM_UNITS;

   initial begin
      assert (TS_W >= 2 && TS_W <= 32) else $error("TS_W out of range");
      assert (NUM_UNITS >= 1 && NUM_UNITS <= 16) else $error("NUM_UNITS out of range");
   end

   logic          hit_ok;
   logic [UW-1:0] busy_vec;
   logic [UW-1:0] expire_vec;
   logic [UW-1:0] free_vec;
   logic [UW-1:0] load_vec;
   logic          drop;
   logic          any_expire;
   logic          coinc_now;
   logic          ovf_q;

   assign hit_ok   = hit_i && mask_i;
   // a slot that expires this cycle counts as free for a new hit
   assign free_vec = ~busy_vec | expire_vec;

   hitdly_alloc #(.NUM_UNITS(UW)) alloc_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (hit_ok),
      .free_i  (free_vec),
      .grant_o (load_vec),
      .drop_o  (drop)
   );

   for (genvar u = 0; u < UW; u++) begin : g_unit
      hitdly_unit #(.TS_W(TS_W)) unit_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .ts_i     (ts_gray_i),
         .load_i   (load_vec[u]),
         .busy_o   (busy_vec[u]),
         .expire_o (expire_vec[u])
      );
   end

   assign any_expire = |expire_vec;
   assign coinc_now  = any_expire && trig_i;

   generate
      if (STROBE_REG) begin : g_reg
         logic coinc_q;
         always_ff @(posedge clk) begin
            if (!rst_n) coinc_q <= 1'b0;
            else        coinc_q <= coinc_now;
         end
         assign coinc_o = coinc_q;

         // R3
         strobe_needs_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
            coinc_o |-> $past(trig_i));
      end else begin : g_comb
         assign coinc_o = coinc_now;

         // R3
         strobe_needs_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
            coinc_o |-> trig_i);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    ovf_q <= 1'b0;
      else if (drop) ovf_q <= 1'b1;
   end
   assign overflow_o = ovf_q;

   // R6
   no_overflow_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overflow_o |=> overflow_o);

   // R7
   mask_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_i |=> ($countones(busy_vec) <= $past($countones(busy_vec)) && !$rose(overflow_o)));

   // R1
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |=> (busy_vec == '0 && !coinc_o && !overflow_o));

endmodule

// File: tb/hitdly_pixel_tb_top.sv
module hitdly_pixel_tb_top;

   localparam int TS_W    = 8;
   localparam int HALF    = 5;
   localparam int PERIOD  = 2 * HALF + 2;
   localparam int MAXC    = 512;
   localparam int END_CYC = 260;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            hit_i;
   logic            mask_i;
   logic [TS_W-1:0] ts_gray_i;
   logic            trig_i;
   logic            coinc_o;
   logic            overflow_o;

   always #4 clk = ~clk;

   hitdly_pixel dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .hit_i      (hit_i),
      .mask_i     (mask_i),
      .ts_gray_i  (ts_gray_i),
      .trig_i     (trig_i),
      .coinc_o    (coinc_o),
      .overflow_o (overflow_o)
   );

   typedef struct {
      int    cyc;
      string tag;
   } exp_t;

   exp_t  exp_q[$];
   logic  hit_plan  [MAXC];
   logic  trig_plan [MAXC];
   logic  mask_plan [MAXC];
   string quiet_tag [MAXC];
   int    cyc    = 0;
   int    checks = 0;
   int    errors = 0;

   function automatic logic [TS_W-1:0] bus_at(int c);
      int t;
      int v;
      t = c % PERIOD;
      v = (t <= HALF) ? t : (PERIOD - 1 - t);
      bus_at = TS_W'(v) ^ (TS_W'(v) >> 1);
   endfunction

   task automatic check(logic ok, string tag, string what, int act, int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", tag, what, cyc, act, expv);
      end
   endtask

   // driver side: schedule stimulus and push the expected strobe cycle
   task automatic plan_hit(int c, logic with_trig, string tag);
      hit_plan[c] = 1'b1;
      if (with_trig) begin
         trig_plan[c + PERIOD] = 1'b1;
         exp_q.push_back('{c + PERIOD + 1, tag});
      end else begin
         quiet_tag[c + PERIOD + 1] = tag;
      end
   endtask

   task automatic plan_silent_hit(int c, logic masked, string tag);
      hit_plan[c] = 1'b1;
      if (masked) mask_plan[c] = 1'b0;
      trig_plan[c + PERIOD] = 1'b1;
      quiet_tag[c + PERIOD + 1] = tag;
   endtask

   task automatic plan_lone_trig(int c, string tag);
      trig_plan[c] = 1'b1;
      quiet_tag[c + 1] = tag;
   endtask

   initial begin
      for (int i = 0; i < MAXC; i++) begin
         hit_plan[i]  = 1'b0;
         trig_plan[i] = 1'b0;
         mask_plan[i] = 1'b1;
         quiet_tag[i] = "";
      end
      // R2: single hit with trigger on time
      plan_hit(20, 1'b1, "R2");
      // R4: expiry without trigger, later nothing
      plan_hit(50, 1'b0, "R4");
      // R3: trigger with no pending hit
      plan_lone_trig(70, "R3");
      // R5: two hits held together
      plan_hit(80, 1'b1, "R5");
      plan_hit(83, 1'b1, "R5");
      // R7: masked hits, then two unmasked ones still find free slots
      plan_silent_hit(100, 1'b1, "R7");
      plan_silent_hit(101, 1'b1, "R7");
      plan_silent_hit(102, 1'b1, "R7");
      plan_hit(103, 1'b1, "R7");
      plan_hit(104, 1'b1, "R7");
      // R6: third hit with both slots busy is dropped
      plan_hit(130, 1'b1, "R6");
      plan_hit(132, 1'b1, "R6");
      plan_silent_hit(134, 1'b0, "R6");
      // R8: hit on the expiry cycle of a busy slot is captured
      plan_hit(160, 1'b1, "R8");
      plan_hit(163, 1'b1, "R8");
      plan_hit(172, 1'b1, "R8");
      // R3: trigger one cycle early and one late around an expiry
      plan_hit(200, 1'b0, "R3");
      plan_lone_trig(211, "R3");
      plan_lone_trig(213, "R3");
   end

   // driver: inputs change 1 ns after the rising edge
   initial begin
      rst_n     = 1'b0;
      hit_i     = 1'b0;
      mask_i    = 1'b1;
      trig_i    = 1'b0;
      ts_gray_i = bus_at(0);
      forever begin
         @(posedge clk);
         #1;
         cyc++;
         if (cyc == 4) rst_n = 1'b1;
         ts_gray_i = bus_at(cyc);
         if (cyc < MAXC) begin
            hit_i  = hit_plan[cyc];
            trig_i = trig_plan[cyc];
            mask_i = mask_plan[cyc];
         end else begin
            hit_i  = 1'b0;
            trig_i = 1'b0;
            mask_i = 1'b1;
         end
      end
   end

   // monitor: sample on the falling edge
   initial begin
      forever begin
         @(negedge clk);
         if (cyc == 2) begin
            check(coinc_o == 1'b0, "R1", "coinc in reset", int'(coinc_o), 0);
            check(overflow_o == 1'b0, "R1", "overflow in reset", int'(overflow_o), 0);
         end
         if (cyc == 5)
            check(coinc_o == 1'b0 && overflow_o == 1'b0, "R1", "state after reset",
                  int'({coinc_o, overflow_o}), 0);
         if (rst_n && cyc < MAXC) begin
            if (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
               check(coinc_o == 1'b1, exp_q[0].tag, "strobe due", int'(coinc_o), 1);
               void'(exp_q.pop_front());
            end else if (quiet_tag[cyc] != "") begin
               check(coinc_o == 1'b0, quiet_tag[cyc], "strobe must stay low", int'(coinc_o), 0);
            end else if (coinc_o) begin
               check(1'b0, "R3", "unexpected strobe", 1, 0);
            end
            if (cyc == 106)
               check(overflow_o == 1'b0, "R7", "overflow after masked hits", int'(overflow_o), 0);
            if (cyc == 125)
               check(overflow_o == 1'b0, "R5", "overflow with two slots used", int'(overflow_o), 0);
            if (cyc == 135)
               check(overflow_o == 1'b1, "R6", "overflow after drop", int'(overflow_o), 1);
            if (cyc == 230)
               check(overflow_o == 1'b1, "R6", "overflow sticky", int'(overflow_o), 1);
         end
      end
   end

   initial begin
      fork
         begin
            wait (cyc >= END_CYC);
         end
         begin
            repeat (20000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual cycle %0d expected %0d", cyc, END_CYC);
         end
      join_any
      while (exp_q.size() > 0) begin
         check(1'b0, exp_q[0].tag, "strobe never seen", 0, exp_q[0].cyc);
         void'(exp_q.pop_front());
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule